// File: doc/BRIEF.md
# Doorbell Mailbox Channel Pair

This block is a single doorbell channel joining two register windows: one used by a sending agent and one by a receiving agent. Both windows share one word of independent flag bits. The sender raises flags by writing ones to a set register. The receiver sees the flags, can hide any of them from its interrupt through a per-bit mask, and retires them by writing ones to a clear register.

Retiring a flag that was pending raises a transfer-acknowledge status bit on the sender side, so the sender learns that the receiver has consumed the doorbell. The sender can also poll its status word and treat a bit that reads zero as complete. Each window has its own interrupt output. Each window also has a control bit that routes its interrupt onto a shared combined interrupt line.

Both windows use a plain word register port: a write strobe with address and data, and a read data bus that follows the address without delay.

Top module: `doorbell_pair`

## Requirements
- R1: After reset all flag bits are 0, all receiver mask bits are 1, the acknowledge bit, the acknowledge enable and both control bits are 0, and `sndIrq`, `rcvIrq` and `cmbIrq` are low.
- R2: A sender write to offset 0x0C sets every flag bit written as 1 from the next cycle on, and leaves bits written as 0 unchanged. The flag word reads back at offset 0x00 of both windows.
- R3: A receiver write to offset 0x08 clears every flag bit written as 1, and leaves bits written as 0 unchanged.
- R4: When a set and a clear hit the same flag bit in the same cycle, the bit ends up 1.
- R5: The acknowledge bit (bit 0 of sender offset 0x10) becomes 1 in the cycle after a receiver clear turns at least one pending flag from 1 to 0. A clear that turns no flag from 1 to 0 leaves the acknowledge bit unchanged.
- R6: A sender write with bit 0 set to offset 0x14 clears the acknowledge bit. If a new acknowledge event happens in the same cycle, the bit stays 1.
- R7: Receiver mask bits read at offset 0x10. A write to 0x14 sets the mask bits written as 1, and a write to 0x18 clears them; nothing else changes the mask. Offset 0x04 reads flags AND NOT mask. `rcvIrq` is high exactly when that word is nonzero.
- R8: The acknowledge enable is bit 0 of sender offset 0x18, readable and writable. `sndIrq` is high exactly when both the acknowledge bit and the enable are 1.
- R9: Bit 0 of offset 0x1C in each window is a combine enable. `cmbIrq` = (`sndIrq` AND sender combine enable) OR (`rcvIrq` AND receiver combine enable).
- R10: Writes to read-only offsets (sender 0x00 and 0x10; receiver 0x00, 0x04 and 0x10) change nothing. Reads of unmapped or write-only offsets return 0. Bits above bit 0 of single-bit registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| sndWr | input | 1 | Sender window write strobe |
| sndAddr | input | ADDR_W | Sender window byte offset |
| sndWdata | input | FLAG_W | Sender window write data |
| sndRdata | output | FLAG_W | Sender window read data for `sndAddr` |
| rcvWr | input | 1 | Receiver window write strobe |
| rcvAddr | input | ADDR_W | Receiver window byte offset |
| rcvWdata | input | FLAG_W | Receiver window write data |
| rcvRdata | output | FLAG_W | Receiver window read data for `rcvAddr` |
| sndIrq | output | 1 | Sender transfer-acknowledge interrupt |
| rcvIrq | output | 1 | Receiver unmasked-doorbell interrupt |
| cmbIrq | output | 1 | Combined interrupt from the windows whose combine enable is set |

## Verification
The hardest situations to reach are the same-cycle collisions between the two windows. One is a set and a clear on the same bit. The other is an acknowledge-clear from the sender in the very cycle a receiver clear retires a pending flag. Neither occurs with one agent at a time. Directed steps drive both ports in one cycle with matched bit patterns, and the random phase then drives both windows together for thousands of cycles, using sparse single-bit data so that sets and clears often land on the same bits.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;

  // Sender window offsets
  localparam int unsigned SND_STATUS  = 'h00;
  localparam int unsigned SND_SET     = 'h0C;
  localparam int unsigned SND_ACK_ST  = 'h10;
  localparam int unsigned SND_ACK_CLR = 'h14;
  localparam int unsigned SND_ACK_EN  = 'h18;
  localparam int unsigned SND_CTRL    = 'h1C;

  // Receiver window offsets
  localparam int unsigned RCV_STATUS  = 'h00;
  localparam int unsigned RCV_MSTAT   = 'h04;
  localparam int unsigned RCV_CLR     = 'h08;
  localparam int unsigned RCV_MASK    = 'h10;
  localparam int unsigned RCV_MSET    = 'h14;
  localparam int unsigned RCV_MCLR    = 'h18;
  localparam int unsigned RCV_CTRL    = 'h1C;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_FLAGS,
    RD_MSTAT,
    RD_MASK,
    RD_ACK,
    RD_ACKEN,
    RD_SCTL,
    RD_RCTL
  } rdSel_e;

  typedef struct packed {
    logic   sSet;
    logic   sAckClr;
    logic   sAckEn;
    logic   sCtrl;
    logic   rClr;
    logic   rMaskSet;
    logic   rMaskClr;
    logic   rCtrl;
    rdSel_e sRd;
    rdSel_e rRd;
  } strobe_t;

endpackage

// File: rtl/doorbell_decode.sv
module doorbell_decode
  import doorbell_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              sndWr,
  input  logic [ADDR_W-1:0] sndAddr,
  input  logic              rcvWr,
  input  logic [ADDR_W-1:0] rcvAddr,
  output strobe_t           stb
);

  always_comb begin
    stb = '0;
    stb.sRd = RD_NONE;
    stb.rRd = RD_NONE;

    // Sender side: writes only to writable offsets, read selection by offset
    if (sndAddr == ADDR_W'(SND_SET))     stb.sSet    = sndWr;
    if (sndAddr == ADDR_W'(SND_ACK_CLR)) stb.sAckClr = sndWr;
    if (sndAddr == ADDR_W'(SND_ACK_EN))  stb.sAckEn  = sndWr;
    if (sndAddr == ADDR_W'(SND_CTRL))    stb.sCtrl   = sndWr;

    if (sndAddr == ADDR_W'(SND_STATUS))      stb.sRd = RD_FLAGS;
    else if (sndAddr == ADDR_W'(SND_ACK_ST)) stb.sRd = RD_ACK;
    else if (sndAddr == ADDR_W'(SND_ACK_EN)) stb.sRd = RD_ACKEN;
    else if (sndAddr == ADDR_W'(SND_CTRL))   stb.sRd = RD_SCTL;

    // Receiver side
    if (rcvAddr == ADDR_W'(RCV_CLR))  stb.rClr     = rcvWr;
    if (rcvAddr == ADDR_W'(RCV_MSET)) stb.rMaskSet = rcvWr;
    if (rcvAddr == ADDR_W'(RCV_MCLR)) stb.rMaskClr = rcvWr;
    if (rcvAddr == ADDR_W'(RCV_CTRL)) stb.rCtrl    = rcvWr;

    if (rcvAddr == ADDR_W'(RCV_STATUS))     stb.rRd = RD_FLAGS;
    else if (rcvAddr == ADDR_W'(RCV_MSTAT)) stb.rRd = RD_MSTAT;
    else if (rcvAddr == ADDR_W'(RCV_MASK))  stb.rRd = RD_MASK;
    else if (rcvAddr == ADDR_W'(RCV_CTRL))  stb.rRd = RD_RCTL;
  end

endmodule

// File: rtl/doorbell_regs.sv
module doorbell_regs
  import doorbell_pkg::*;
#(
  parameter int FLAG_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [FLAG_W-1:0] sndWdata,
  input  logic [FLAG_W-1:0] rcvWdata,
  output logic [FLAG_W-1:0] sndRdata,
  output logic [FLAG_W-1:0] rcvRdata,
  output logic [FLAG_W-1:0] flagsQ,
  output logic [FLAG_W-1:0] maskQ,
  output logic              ackQ,
  output logic              ackEnQ,
  output logic              sCtlQ,
  output logic              rCtlQ,
  output logic              sndIrq,
  output logic              rcvIrq
);

  logic [FLAG_W-1:0] setVec;
  logic [FLAG_W-1:0] clrVec;
  logic [FLAG_W-1:0] visible;
  logic              ackEvent;

  assign setVec = stb.sSet ? sndWdata : '0;
  assign clrVec = stb.rClr ? rcvWdata : '0;

  // One flag cell per doorbell bit; a set beats a clear on the same bit
  for (genvar i = 0; i < FLAG_W; i++) begin : gFlag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          flagsQ[i] <= 1'b0;
      else if (setVec[i]) flagsQ[i] <= 1'b1;
      else if (clrVec[i]) flagsQ[i] <= 1'b0;
    end
  end

  // An acknowledge fires only when a pending bit actually falls
  assign ackEvent = |(flagsQ & clrVec & ~setVec);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          ackQ <= 1'b0;
    else if (ackEvent)                  ackQ <= 1'b1;
    else if (stb.sAckClr && sndWdata[0]) ackQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            maskQ <= '1;
    else if (stb.rMaskSet) maskQ <= maskQ | rcvWdata;
    else if (stb.rMaskClr) maskQ <= maskQ & ~rcvWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackEnQ <= 1'b0;
      sCtlQ  <= 1'b0;
      rCtlQ  <= 1'b0;
    end else begin
      if (stb.sAckEn) ackEnQ <= sndWdata[0];
      if (stb.sCtrl)  sCtlQ  <= sndWdata[0];
      if (stb.rCtrl)  rCtlQ  <= rcvWdata[0];
    end
  end

  assign visible = flagsQ & ~maskQ;
  assign sndIrq  = ackQ & ackEnQ;
  assign rcvIrq  = |visible;

  function automatic logic [FLAG_W-1:0] pick(input rdSel_e sel,
                                             input logic [FLAG_W-1:0] fl,
                                             input logic [FLAG_W-1:0] vis,
                                             input logic [FLAG_W-1:0] msk,
                                             input logic ack, input logic en,
                                             input logic sc, input logic rc);
    case (sel)
      RD_FLAGS: pick = fl;
      RD_MSTAT: pick = vis;
      RD_MASK:  pick = msk;
      RD_ACK:   pick = FLAG_W'(ack);
      RD_ACKEN: pick = FLAG_W'(en);
      RD_SCTL:  pick = FLAG_W'(sc);
      RD_RCTL:  pick = FLAG_W'(rc);
      default:  pick = '0;
    endcase
  endfunction

  assign sndRdata = pick(stb.sRd, flagsQ, visible, maskQ, ackQ, ackEnQ, sCtlQ, rCtlQ);
  assign rcvRdata = pick(stb.rRd, flagsQ, visible, maskQ, ackQ, ackEnQ, sCtlQ, rCtlQ);

endmodule

// File: rtl/doorbell_pair.sv
module doorbell_pair
  import doorbell_pkg::*;
#(
  parameter int FLAG_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sndWr,
  input  logic [ADDR_W-1:0] sndAddr,
  input  logic [FLAG_W-1:0] sndWdata,
  output logic [FLAG_W-1:0] sndRdata,
  input  logic              rcvWr,
  input  logic [ADDR_W-1:0] rcvAddr,
  input  logic [FLAG_W-1:0] rcvWdata,
  output logic [FLAG_W-1:0] rcvRdata,
  output logic              sndIrq,
  output logic              rcvIrq,
  output logic              cmbIrq
);

  strobe_t           stb;
  logic [FLAG_W-1:0] flagsQ;
  logic [FLAG_W-1:0] maskQ;
  logic              ackQ;
  logic              ackEnQ;
  logic              sCtlQ;
  logic              rCtlQ;

  doorbell_decode #(.ADDR_W(ADDR_W)) u_decode (
    .sndWr   (sndWr),
    .sndAddr (sndAddr),
    .rcvWr   (rcvWr),
    .rcvAddr (rcvAddr),
    .stb     (stb)
  );

  doorbell_regs #(.FLAG_W(FLAG_W)) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .sndWdata (sndWdata),
    .rcvWdata (rcvWdata),
    .sndRdata (sndRdata),
    .rcvRdata (rcvRdata),
    .flagsQ   (flagsQ),
    .maskQ    (maskQ),
    .ackQ     (ackQ),
    .ackEnQ   (ackEnQ),
    .sCtlQ    (sCtlQ),
    .rCtlQ    (rCtlQ),
    .sndIrq   (sndIrq),
    .rcvIrq   (rcvIrq)
  );

  assign cmbIrq = (sndIrq & sCtlQ) | (rcvIrq & rCtlQ);

endmodule

// File: rtl/doorbell_pair_chk.sv
module doorbell_pair_chk
  import doorbell_pkg::*;
#(
  parameter int FLAG_W = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              sndWr,
  input logic [ADDR_W-1:0] sndAddr,
  input logic [FLAG_W-1:0] sndWdata,
  input logic              rcvWr,
  input logic [ADDR_W-1:0] rcvAddr,
  input logic [FLAG_W-1:0] rcvWdata,
  input logic              sndIrq,
  input logic              rcvIrq,
  input logic              cmbIrq,
  input logic [FLAG_W-1:0] flagsQ,
  input logic [FLAG_W-1:0] maskQ,
  input logic              ackQ,
  input logic              ackEnQ
);

  // R2
  set_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sndWr && sndAddr == ADDR_W'(SND_SET)) |=> ((flagsQ & $past(sndWdata)) == $past(sndWdata)));

  // R3
  clear_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rcvWr && rcvAddr == ADDR_W'(RCV_CLR) && !sndWr) |=> ((flagsQ & $past(rcvWdata)) == '0));

  // R2
  flags_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sndWr && !rcvWr) |=> $stable(flagsQ));

  // R5
  ack_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(flagsQ) & ~flagsQ)) |-> ackQ);

  // R7
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rcvWr |=> $stable(maskQ));

  // R7
  full_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (&maskQ) |-> !rcvIrq);

  // R8
  ack_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ackQ && ackEnQ) |-> !sndIrq);

  // R9
  cmb_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmbIrq |-> (sndIrq || rcvIrq));

endmodule

bind doorbell_pair doorbell_pair_chk #(.FLAG_W(FLAG_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sndWr    (sndWr),
  .sndAddr  (sndAddr),
  .sndWdata (sndWdata),
  .rcvWr    (rcvWr),
  .rcvAddr  (rcvAddr),
  .rcvWdata (rcvWdata),
  .sndIrq   (sndIrq),
  .rcvIrq   (rcvIrq),
  .cmbIrq   (cmbIrq),
  .flagsQ   (flagsQ),
  .maskQ    (maskQ),
  .ackQ     (ackQ),
  .ackEnQ   (ackEnQ)
);

// File: tb/doorbell_pair_tb.sv
`timescale 1ns/1ps
module doorbell_pair_tb;
  localparam int W  = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sndWr = 1'b0;
  logic [AW-1:0] sndAddr = '0;
  logic [W-1:0]  sndWdata = '0;
  logic [W-1:0]  sndRdata;
  logic          rcvWr = 1'b0;
  logic [AW-1:0] rcvAddr = '0;
  logic [W-1:0]  rcvWdata = '0;
  logic [W-1:0]  rcvRdata;
  logic          sndIrq, rcvIrq, cmbIrq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // Bench model of the register state
  logic [W-1:0] mFlags, mMask;
  logic         mAck, mAckEn, mSCtl, mRCtl;

  always #4 clk = ~clk;

  doorbell_pair #(.FLAG_W(W), .ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN),
    .sndWr(sndWr), .sndAddr(sndAddr), .sndWdata(sndWdata), .sndRdata(sndRdata),
    .rcvWr(rcvWr), .rcvAddr(rcvAddr), .rcvWdata(rcvWdata), .rcvRdata(rcvRdata),
    .sndIrq(sndIrq), .rcvIrq(rcvIrq), .cmbIrq(cmbIrq)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void modelReset();
    mFlags = '0; mMask = '1; mAck = 1'b0; mAckEn = 1'b0; mSCtl = 1'b0; mRCtl = 1'b0;
  endfunction

  function automatic logic [W-1:0] expSnd(input logic [AW-1:0] a);
    case (a)
      5'h00:   return mFlags;
      5'h10:   return {31'b0, mAck};
      5'h18:   return {31'b0, mAckEn};
      5'h1C:   return {31'b0, mSCtl};
      default: return '0;
    endcase
  endfunction

  function automatic logic [W-1:0] expRcv(input logic [AW-1:0] a);
    case (a)
      5'h00:   return mFlags;
      5'h04:   return mFlags & ~mMask;
      5'h10:   return mMask;
      5'h1C:   return {31'b0, mRCtl};
      default: return '0;
    endcase
  endfunction

  function automatic void modelStep(input logic sW, input logic [AW-1:0] sA, input logic [W-1:0] sD,
                                    input logic rW, input logic [AW-1:0] rA, input logic [W-1:0] rD);
    logic [W-1:0] setV, clrV;
    logic ev;
    setV = (sW && sA == 5'h0C) ? sD : '0;
    clrV = (rW && rA == 5'h08) ? rD : '0;
    ev = |(mFlags & clrV & ~setV);
    mFlags = (mFlags & ~clrV) | setV;
    if (ev) mAck = 1'b1;
    else if (sW && sA == 5'h14 && sD[0]) mAck = 1'b0;
    if (sW && sA == 5'h18) mAckEn = sD[0];
    if (sW && sA == 5'h1C) mSCtl = sD[0];
    if (rW && rA == 5'h14) mMask = mMask | rD;
    if (rW && rA == 5'h18) mMask = mMask & ~rD;
    if (rW && rA == 5'h1C) mRCtl = rD[0];
  endfunction

  task automatic both(input logic sW, input logic [AW-1:0] sA, input logic [W-1:0] sD,
                      input logic rW, input logic [AW-1:0] rA, input logic [W-1:0] rD);
    @(negedge clk);
    sndWr = sW; sndAddr = sA; sndWdata = sD;
    rcvWr = rW; rcvAddr = rA; rcvWdata = rD;
    @(negedge clk);
    sndWr = 1'b0; rcvWr = 1'b0;
  endtask

  task automatic sw(input logic [AW-1:0] a, input logic [W-1:0] d);
    both(1'b1, a, d, 1'b0, 5'h00, '0);
  endtask

  task automatic rw(input logic [AW-1:0] a, input logic [W-1:0] d);
    both(1'b0, 5'h00, '0, 1'b1, a, d);
  endtask

  task automatic chkS(input string tag, input logic [AW-1:0] a, input logic [W-1:0] exp);
    @(negedge clk);
    sndAddr = a;
    #1 chk(tag, sndRdata, exp);
  endtask

  task automatic chkR(input string tag, input logic [AW-1:0] a, input logic [W-1:0] exp);
    @(negedge clk);
    rcvAddr = a;
    #1 chk(tag, rcvRdata, exp);
  endtask

  task automatic chkIrq(input string tag, input logic s, input logic r, input logic c);
    @(negedge clk);
    #1;
    chk({tag, " sndIrq"}, {31'b0, sndIrq}, {31'b0, s});
    chk({tag, " rcvIrq"}, {31'b0, rcvIrq}, {31'b0, r});
    chk({tag, " cmbIrq"}, {31'b0, cmbIrq}, {31'b0, c});
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    modelReset();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chkS("R1 flags", 5'h00, 32'h0);
    chkR("R1 mask", 5'h10, 32'hFFFF_FFFF);
    chkS("R1 ack", 5'h10, 32'h0);
    chkS("R1 ackEn", 5'h18, 32'h0);
    chkIrq("R1", 1'b0, 1'b0, 1'b0);

    // R2 set, visible in both windows
    sw(5'h0C, 32'h5);
    chkS("R2 snd status", 5'h00, 32'h5);
    chkR("R2 rcv status", 5'h00, 32'h5);
    chkR("R7 masked view", 5'h04, 32'h0);

    // R7 mask set/clear
    rw(5'h18, 32'h1);
    chkR("R7 mask after clr", 5'h10, 32'hFFFF_FFFE);
    chkR("R7 masked view", 5'h04, 32'h1);
    chkIrq("R7 unmasked", 1'b0, 1'b1, 1'b0);
    rw(5'h14, 32'h1);
    chkIrq("R7 remasked", 1'b0, 1'b0, 1'b0);
    rw(5'h18, 32'hF);
    chkR("R7 mask", 5'h10, 32'hFFFF_FFF0);

    // R8 enable, upper bits read zero (R10)
    sw(5'h18, 32'hFFFF_FFFF);
    chkS("R8 R10 ackEn", 5'h18, 32'h1);

    // R3 clear, R5 acknowledge
    rw(5'h08, 32'h1);
    chkS("R3 flags after clear", 5'h00, 32'h4);
    chkS("R5 ack raised", 5'h10, 32'h1);
    chkIrq("R8 ack irq", 1'b1, 1'b1, 1'b0);

    // R6 clear acknowledge
    sw(5'h14, 32'h1);
    chkS("R6 ack cleared", 5'h10, 32'h0);

    // R5 clearing a non-pending bit is no event
    rw(5'h08, 32'h2);
    chkS("R5 no event ack", 5'h10, 32'h0);
    chkS("R5 no event flags", 5'h00, 32'h4);

    // R4 collisions: pending bit and idle bit
    both(1'b1, 5'h0C, 32'h4, 1'b1, 5'h08, 32'h4);
    chkS("R4 pending stays", 5'h00, 32'h4);
    chkS("R4 no ack", 5'h10, 32'h0);
    both(1'b1, 5'h0C, 32'h10, 1'b1, 5'h08, 32'h10);
    chkS("R4 idle set wins", 5'h00, 32'h14);

    // R6 raise beats clear
    rw(5'h08, 32'h10);
    chkS("R6 ack pre", 5'h10, 32'h1);
    both(1'b1, 5'h14, 32'h1, 1'b1, 5'h08, 32'h4);
    chkS("R6 raise wins", 5'h10, 32'h1);
    chkS("R6 flags", 5'h00, 32'h0);

    // R9 combined interrupt
    chkIrq("R9 no combine", 1'b1, 1'b0, 1'b0);
    sw(5'h1C, 32'h1);
    chkS("R9 sctl", 5'h1C, 32'h1);
    chkIrq("R9 snd combine", 1'b1, 1'b0, 1'b1);
    sw(5'h14, 32'h1);
    chkIrq("R9 snd gone", 1'b0, 1'b0, 1'b0);
    sw(5'h0C, 32'h1);
    chkIrq("R9 rcv not combined", 1'b0, 1'b1, 1'b0);
    rw(5'h1C, 32'h1);
    chkR("R9 rctl", 5'h1C, 32'h1);
    chkIrq("R9 rcv combine", 1'b0, 1'b1, 1'b1);

    // R10 read-only writes ignored, unmapped reads zero
    sw(5'h00, 32'hFFFF_FFFF);
    chkS("R10 snd status ro", 5'h00, 32'h1);
    sw(5'h10, 32'h1);
    chkS("R10 ack ro", 5'h10, 32'h0);
    rw(5'h00, 32'hFFFF_FFFF);
    rw(5'h04, 32'hFFFF_FFFF);
    chkR("R10 rcv status ro", 5'h00, 32'h1);
    rw(5'h10, 32'hFFFF_FFFF);
    chkR("R10 mask ro", 5'h10, 32'hFFFF_FFF0);
    chkR("R10 clr reads 0", 5'h08, 32'h0);
    chkR("R10 unmapped rcv", 5'h0C, 32'h0);
    chkS("R10 set reads 0", 5'h0C, 32'h0);
    chkS("R10 ackclr reads 0", 5'h14, 32'h0);
    chkS("R10 unmapped snd", 5'h04, 32'h0);
    chkS("R10 unaligned", 5'h01, 32'h0);

    // Random phase on both windows against the model
    doReset();
    for (int i = 0; i < 3000; i++) begin
      logic sW, rW;
      logic [AW-1:0] sA, rA;
      logic [W-1:0] sD, rD;
      @(negedge clk);
      sW = $urandom_range(0, 1) == 1;
      rW = $urandom_range(0, 1) == 1;
      sA = ($urandom_range(0, 15) == 0) ? AW'($urandom) : {3'($urandom), 2'b00};
      rA = ($urandom_range(0, 15) == 0) ? AW'($urandom) : {3'($urandom), 2'b00};
      sD = ($urandom_range(0, 3) == 0) ? $urandom : (32'h1 << $urandom_range(0, 7));
      rD = ($urandom_range(0, 3) == 0) ? $urandom : (32'h1 << $urandom_range(0, 7));
      sndWr = sW; sndAddr = sA; sndWdata = sD;
      rcvWr = rW; rcvAddr = rA; rcvWdata = rD;
      #1;
      chk("R10 rnd snd read", sndRdata, expSnd(sA));
      chk("R7 rnd rcv read", rcvRdata, expRcv(rA));
      chk("R8 rnd sndIrq", {31'b0, sndIrq}, {31'b0, mAck & mAckEn});
      chk("R7 rnd rcvIrq", {31'b0, rcvIrq}, {31'b0, |(mFlags & ~mMask)});
      chk("R9 rnd cmbIrq", {31'b0, cmbIrq},
          {31'b0, ((mAck & mAckEn) & mSCtl) | ((|(mFlags & ~mMask)) & mRCtl)});
      modelStep(sW, sA, sD, rW, rA, rD);
    end
    @(negedge clk);
    sndWr = 1'b0; rcvWr = 1'b0;
    chkS("R2 final flags", 5'h00, mFlags);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule